// File: doc/BRIEF.md
# Timer Capture Unit with Clear Options

This block pairs a 16-bit auxiliary up/down timer and a second 16-bit up/down timer with a capture register. A trigger event latches the auxiliary timer's current value into the capture register and produces a one-cycle interrupt pulse. The trigger can come from one of two places. The first is a dedicated capture pin. The second is the pair of external inputs that belong to the second timer: its count input and its direction input. An edge-mode input decides which transitions count as triggers.

The same trigger can also clear the auxiliary timer, the second timer, or both. Each clear has its own enable. The capture enable only controls whether the capture register is written. Clears and the interrupt still happen when capture is disabled. A clear always acts after the old auxiliary value has been latched.

All control bits are plain input ports. Each timer has a run enable and a direction input. External inputs pass through a two-flop synchroniser before edge detection.

Top module: `cap_unit`

## Requirements
- R1: On a trigger with `cap_en`=1, `cap_value` takes the value `aux_count` held in the cycle before the capture edge. This is the value before that edge's count or clear update.
- R2: `cap_irq` is high for exactly one clock cycle per isolated trigger event.
- R3: With `aux_clr_en`=1, a trigger makes `aux_count` read 0 in the cycle after the capture edge. With `aux_clr_en`=0, a trigger leaves `aux_count` unchanged.
- R4: With `t2_clr_en`=1, a trigger makes `t2_count` read 0 in the cycle after the capture edge. With `t2_clr_en`=0, `t2_count` is unaffected.
- R5: With `cap_en`=0, a trigger leaves `cap_value` unchanged, but it still pulses `cap_irq` and still performs any enabled clears.
- R6: With `src_sel`=0, only `cap_pin` can trigger. With `src_sel`=1, only transitions of `t2_cnt_in` or `t2_dir_in` can trigger, and either one alone is enough.
- R7: `edge_sel` encoding is as follows: 2'b00 gives no triggers, 2'b01 triggers on rising edges, 2'b10 on falling edges, and 2'b11 on both.
- R8: `cap_irq` and the capture or clear results appear after the third rising clock edge following an input change. The delay comes from the two synchroniser flops plus one result register.
- R9: Each timer counts by one per cycle while its run input is 1. It counts up when its direction input is 1 and down when it is 0, and it wraps at both ends. While run is 0 and no clear occurs, it holds. A clear wins over counting in the same cycle.
- R10: While `rst_n` is low at a rising edge, both timers, `cap_value` and `cap_irq` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Dedicated capture trigger pin (asynchronous) |
| t2_cnt_in | input | 1 | Second timer's external count input, used as a trigger source |
| t2_dir_in | input | 1 | Second timer's external direction input, used as a trigger source |
| src_sel | input | 1 | Trigger source: 0 selects the capture pin, 1 selects the second timer's inputs |
| edge_sel | input | 2 | Edge mode: 00 off, 01 rising, 10 falling, 11 both |
| cap_en | input | 1 | Allows the capture register to be written |
| aux_clr_en | input | 1 | A trigger clears the auxiliary timer |
| t2_clr_en | input | 1 | A trigger clears the second timer |
| aux_run | input | 1 | Auxiliary timer count enable |
| aux_up | input | 1 | Auxiliary timer direction, 1 = up |
| t2_run | input | 1 | Second timer count enable |
| t2_up | input | 1 | Second timer direction, 1 = up |
| aux_count | output | 16 | Auxiliary timer value |
| t2_count | output | 16 | Second timer value |
| cap_value | output | 16 | Capture register |
| cap_irq | output | 1 | One-cycle capture interrupt pulse |

## Verification
The assertions assume that the control inputs (`edge_sel`, `src_sel`, the enables and the run and direction bits) are synchronous to `clk`. They also assume that reset is held low for at least one full cycle, so the stability checks begin from known register values. The stimulus changes every input only on the falling edge. It leaves the trigger pins quiet for several cycles between events, so each check sees one isolated pulse. Edge mode and source are switched only while the synchronised inputs are stable.

// File: rtl/cap_pkg.sv
// Package: shared types for the timer capture unit.
// Assumes: nothing beyond the standard; used by every module of the block.
package cap_pkg;

    // Edge mode encoding; the values match the edge_sel input port.
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    // Trigger input lanes, in the order they are packed at the top.
    localparam int unsigned N_TRIG_IN = 3;
    localparam int unsigned LANE_PIN  = 0;
    localparam int unsigned LANE_CNT  = 1;
    localparam int unsigned LANE_DIR  = 2;

endpackage

// File: rtl/cap_sync.sv
// Module: cap_sync
// Multi-stage synchroniser for a vector of asynchronous single-bit inputs.
// Assumes: each bit is independent (no bus coherency needed); STAGES >= 2.
module cap_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
// Module: cap_edge
// Detects the selected transitions on one synchronised input.
// Assumes: sig is already synchronous to clk; mode is quasi-static.
// The pulse is combinational and valid in the cycle after sig changes.
module cap_edge
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig,
    input  edge_mode_e mode,
    output logic       pulse
);
    logic sig_q;
    logic rise, fall;

    // Keep last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;

    // Map the edge mode onto the detected transitions.
    always_comb begin
        unique case (mode)
            EDGE_RISE: pulse = rise;
            EDGE_FALL: pulse = fall;
            EDGE_ANY:  pulse = rise | fall;
            default:   pulse = 1'b0;
        endcase
    end

    AST_EDGE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_OFF) |-> !pulse); // R7
    AST_RISE_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && mode == EDGE_RISE) |-> (sig && !sig_q)); // R7
endmodule

// File: rtl/cap_counter.sv
// Module: cap_counter
// Simple up/down wrap-around counter with run enable and synchronous clear.
// Assumes: clr has priority over counting; all controls synchronous to clk.
module cap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         up,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = W'(1);

    // Clear first, otherwise step in the chosen direction when running.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (run) cnt <= up ? cnt + ONE : cnt - ONE;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt)); // R9
    AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && up && !clr && cnt == '1) |=> (cnt == '0)); // R9
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !up && !clr && cnt == '0) |=> (cnt == '1)); // R9
endmodule

// File: rtl/cap_unit.sv
// Module: cap_unit (top)
// Capture unit: synchronises the trigger pins, detects the selected edges,
// picks the trigger source, latches the auxiliary timer into the capture
// register, pulses the interrupt and optionally clears either timer.
// Assumes: control inputs are synchronous to clk; trigger pins are
// asynchronous and are synchronised here.
module cap_unit
    import cap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic             t2_cnt_in,
    input  logic             t2_dir_in,
    input  logic             src_sel,
    input  logic [1:0]       edge_sel,
    input  logic             cap_en,
    input  logic             aux_clr_en,
    input  logic             t2_clr_en,
    input  logic             aux_run,
    input  logic             aux_up,
    input  logic             t2_run,
    input  logic             t2_up,
    output logic [CNT_W-1:0] aux_count,
    output logic [CNT_W-1:0] t2_count,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_irq
);
    logic [N_TRIG_IN-1:0] raw_in;
    logic [N_TRIG_IN-1:0] synced;
    logic [N_TRIG_IN-1:0] hit;
    logic                 trig;
    edge_mode_e           mode;

    assign raw_in[LANE_PIN] = cap_pin;
    assign raw_in[LANE_CNT] = t2_cnt_in;
    assign raw_in[LANE_DIR] = t2_dir_in;
    assign mode             = edge_mode_e'(edge_sel);

    cap_sync #(.W(N_TRIG_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (synced)
    );

    genvar g;
    generate
        for (g = 0; g < N_TRIG_IN; g++) begin : g_edge
            cap_edge u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .sig   (synced[g]),
                .mode  (mode),
                .pulse (hit[g])
            );
        end
    endgenerate

    // Source selection: the dedicated pin, or either second-timer input.
    assign trig = src_sel ? (hit[LANE_CNT] | hit[LANE_DIR]) : hit[LANE_PIN];

    cap_counter #(.W(CNT_W)) u_aux (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (aux_run),
        .up    (aux_up),
        .clr   (trig & aux_clr_en),
        .cnt   (aux_count)
    );

    cap_counter #(.W(CNT_W)) u_t2 (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (t2_run),
        .up    (t2_up),
        .clr   (trig & t2_clr_en),
        .cnt   (t2_count)
    );

    // Capture register: latch the pre-update auxiliary value when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)              cap_value <= '0;
        else if (trig && cap_en) cap_value <= aux_count;
    end

    // Interrupt pulse: one cycle per trigger, independent of cap_en.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_irq <= 1'b0;
        else        cap_irq <= trig;
    end

    AST_CAP_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_irq |-> $stable(cap_value)); // R1
    AST_CAP_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_irq && !$past(cap_en)) |-> $stable(cap_value)); // R5
    AST_CAP_TAKES_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_irq && $past(cap_en)) |-> (cap_value == $past(aux_count))); // R1
    AST_AUX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_irq && $past(aux_clr_en)) |-> (aux_count == '0)); // R3
    AST_T2_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_irq && $past(t2_clr_en)) |-> (t2_count == '0)); // R4
    AST_T2_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_irq && !$past(t2_clr_en) && !$past(t2_run)) |-> $stable(t2_count)); // R4
endmodule

// File: tb/sim_cap_unit.sv
`timescale 1ns/1ps
module sim_cap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0, t2_cnt_in = 1'b0, t2_dir_in = 1'b0;
    logic        src_sel = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        cap_en = 1'b0, aux_clr_en = 1'b0, t2_clr_en = 1'b0;
    logic        aux_run = 1'b0, aux_up = 1'b1, t2_run = 1'b0, t2_up = 1'b1;
    logic [15:0] aux_count, t2_count, cap_value;
    logic        cap_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cap_unit u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .t2_cnt_in(t2_cnt_in),
        .t2_dir_in(t2_dir_in), .src_sel(src_sel), .edge_sel(edge_sel),
        .cap_en(cap_en), .aux_clr_en(aux_clr_en), .t2_clr_en(t2_clr_en),
        .aux_run(aux_run), .aux_up(aux_up), .t2_run(t2_run), .t2_up(t2_up),
        .aux_count(aux_count), .t2_count(t2_count), .cap_value(cap_value),
        .cap_irq(cap_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watch six cycles after a stimulus applied at a negedge: first pulse
    // position, pulse count, and aux_count just before the capture edge.
    task automatic watch(output int at, output int cnt, output logic [15:0] aux_pre);
        logic [15:0] prev;
        at = 0; cnt = 0; aux_pre = '0;
        for (int i = 1; i <= 6; i++) begin
            prev = aux_count;
            @(negedge clk);
            if (cap_irq) begin
                cnt++;
                if (at == 0) begin at = i; aux_pre = prev; end
            end
        end
    endtask

    task automatic t_reset;
        chk("R10", "aux_count", aux_count, 0);
        chk("R10", "t2_count", t2_count, 0);
        chk("R10", "cap_value", cap_value, 0);
        chk("R10", "cap_irq", cap_irq, 0);
    endtask

    task automatic t_counters;
        aux_run = 1; aux_up = 1; cycles(5); aux_run = 0;
        chk("R9", "aux up 5", aux_count, 16'd5);
        aux_run = 1; aux_up = 0; cycles(7); aux_run = 0;
        chk("R9", "aux down wrap", aux_count, 16'hFFFE);
        cycles(3);
        chk("R9", "aux holds", aux_count, 16'hFFFE);
        t2_run = 1; t2_up = 1; cycles(3); t2_run = 0;
        chk("R9", "t2 up 3", t2_count, 16'd3);
    endtask

    task automatic t_rise_pin;
        int at, n; logic [15:0] pre;
        src_sel = 0; edge_sel = 2'b01; cap_en = 1; cycles(2);
        cap_pin = 1;
        watch(at, n, pre);
        chk("R8", "irq latency", at, 3);
        chk("R2", "one pulse", n, 1);
        chk("R1", "captured aux", cap_value, 16'hFFFE);
        chk("R3", "aux kept when clr off", aux_count, 16'hFFFE);
        chk("R4", "t2 kept when clr off", t2_count, 16'd3);
    endtask

    task automatic t_edge_modes;
        int at, n; logic [15:0] pre;
        cap_pin = 0; watch(at, n, pre);
        chk("R7", "fall ignored in rise mode", n, 0);
        edge_sel = 2'b10; cap_pin = 1; watch(at, n, pre);
        chk("R7", "rise ignored in fall mode", n, 0);
        cap_pin = 0; watch(at, n, pre);
        chk("R7", "fall detected in fall mode", n, 1);
        edge_sel = 2'b11; cap_pin = 1; watch(at, n, pre);
        chk("R7", "rise in both mode", n, 1);
        cap_pin = 0; watch(at, n, pre);
        chk("R7", "fall in both mode", n, 1);
        edge_sel = 2'b00; cap_pin = 1; watch(at, n, pre);
        chk("R7", "off mode rise", n, 0);
        cap_pin = 0; watch(at, n, pre);
        chk("R7", "off mode fall", n, 0);
    endtask

    task automatic t_aux_clear_running;
        int at, n; logic [15:0] pre;
        edge_sel = 2'b01; aux_clr_en = 1; aux_up = 1; aux_run = 1; cycles(2);
        cap_pin = 1; watch(at, n, pre);
        aux_run = 0;
        chk("R1", "capture of running timer", cap_value, pre);
        chk("R3", "irq seen", n, 1);
        // Clear happened at pulse position; three quiet cycles of counting
        // followed before run was dropped.
        chk("R3", "aux after clear and 3 counts", aux_count, 16'd3);
        aux_clr_en = 0;
    endtask

    task automatic t_t2_clear_capdis;
        int at, n; logic [15:0] old_cap;
        cap_pin = 0; cycles(6);
        old_cap = cap_value;
        cap_en = 0; t2_clr_en = 1; aux_clr_en = 1; cycles(1);
        cap_pin = 1; watch(at, n, old_cap);
        chk("R5", "irq while capture off", n, 1);
        chk("R5", "cap_value unchanged", cap_value, pre_cap_saved);
        chk("R4", "t2 cleared", t2_count, 0);
        chk("R5", "aux cleared while capture off", aux_count, 0);
        cap_en = 1; t2_clr_en = 0; aux_clr_en = 0;
    endtask

    logic [15:0] pre_cap_saved;

    task automatic t_source;
        int at, n; logic [15:0] pre;
        aux_run = 1; aux_up = 1; cycles(4); aux_run = 0;
        cap_pin = 0; cycles(6);
        src_sel = 1; edge_sel = 2'b01; cycles(1);
        pre_cap_saved = cap_value;
        cap_pin = 1; watch(at, n, pre);
        chk("R6", "pin ignored when src=1", n, 0);
        chk("R6", "cap kept when pin ignored", cap_value, pre_cap_saved);
        t2_cnt_in = 1; watch(at, n, pre);
        chk("R6", "count input triggers", n, 1);
        chk("R1", "capture via count input", cap_value, 16'd4);
        t2_dir_in = 1; watch(at, n, pre);
        chk("R6", "direction input triggers", n, 1);
        src_sel = 0; cap_pin = 0; cycles(2);
        t2_cnt_in = 0; t2_dir_in = 0; edge_sel = 2'b11; cycles(1);
        watch(at, n, pre);
        chk("R6", "second timer inputs ignored when src=0", n, 0);
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counters();
        t_rise_pin();
        t_edge_modes();
        t_aux_clear_running();
        pre_cap_saved = cap_value;
        t_t2_clear_capdis();
        t_source();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule